// File: doc/BRIEF.md
# Keyed Configuration Item Register Port

This block is a slave register port through which a host pulls small read-only byte blobs out of an internal item store. The host first writes a 16-bit key to the selector register. It then reads the chosen item through a data register. Each read returns the next 1, 2, 4 or 8 bytes of the item and moves an internal byte offset forward by the same amount, so an item streams out across consecutive reads.

The store is computed from parameters. It holds two fixed items and a set of generated ones:

- A four-byte signature item lets software confirm that the port exists.
- A 32-bit feature word reports the optional capabilities.
- Generic and architecture-specific items have parameterized counts, with lengths and contents derived from their index.

Reading beyond an item's end yields zero bytes. Keys that name no item act as empty items.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the selected key is 0x0000, the byte offset is 0, `dat_rdata` is zero and `dat_rvalid` is low.
- R2: A cycle with `sel_we` high loads `sel_wdata` as the key and rewinds the offset to 0. A `dat_re` in the same cycle is dropped and produces no `dat_rvalid`.
- R3: A read accepted at a clock edge (`dat_re` high, `sel_we` low) presents its data on `dat_rdata` with `dat_rvalid` high for exactly the following cycle. In any other cycle `dat_rvalid` is low.
- R4: `dat_size` selects the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Byte lane k (`dat_rdata[8k+7:8k]`) carries the item byte at offset+k, and lanes at or above the width read zero. The offset then advances by the width.
- R5: Item bytes at positions at or beyond the item length read 0x00. The offset saturates at the item length and never wraps.
- R6: Key bit 15 selects the architecture-specific space and bits 13:0 give the index within that space. Bit 14 does not influence which item is read.
- R7: Generic index 0 is the signature item. Its length is 4, and offsets 0 to 3 hold the bytes of parameter `SIG` from its most significant byte down. The default `SIG` gives the ASCII characters "KCFG".
- R8: Generic index 1 is a 4-byte little-endian feature word. Bit 0 is always 1 and bit 1 equals parameter `FEAT_BULK` (default 1), so the default bytes are 03 00 00 00.
- R9: Generic index i with 2 <= i < `N_GEN` has length 3*i, and its byte at offset p is (16*i + p) mod 256. Architecture index j < `N_ARCH` has length 2*j+5, and its byte at offset p is (0x80 + 16*j + p) mod 256. Every other key is an item of length 0.
- R10: `dat_we` and `dat_wdata` have no effect: a data write leaves the offset and the read data stream unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_we | input | 1 | Selector write strobe |
| sel_wdata | input | 16 | Key written to the selector |
| dat_re | input | 1 | Data read strobe |
| dat_we | input | 1 | Data write strobe (no effect) |
| dat_size | input | 2 | Access width code: 0 is 1 byte, 1 is 2, 2 is 4, 3 is 8 |
| dat_wdata | input | 64 | Data write value (no effect) |
| dat_rdata | output | 64 | Read data, lowest offset in lane 0 |
| dat_rvalid | output | 1 | Read data valid, one cycle after the read |

## Verification
The assertions assume that the strobes are synchronous to `clk` and that `dat_size` is meaningful only while `dat_re` is high. They also assume that the offset never exceeds the length of the selected item, which holds because the offset is rewound on every key change. The stimulus drives all inputs at the falling edge and holds each strobe for one cycle. Its sequences combine selector writes with simultaneous reads, data writes between reads, and reads that run past the end of an item. It also uses keys that differ only in bit 14 or bit 15, as well as keys that name no item.

// File: rtl/kcfg_pkg.sv
package kcfg_pkg;
    typedef enum logic [1:0] {
        ACC_B1 = 2'd0,
        ACC_B2 = 2'd1,
        ACC_B4 = 2'd2,
        ACC_B8 = 2'd3
    } acc_size_e;

    localparam int unsigned LANES = 8;

    function automatic int unsigned acc_bytes(acc_size_e s);
        return 32'd1 << s;
    endfunction
endpackage

// File: rtl/cfg_item_map.sv
module cfg_item_map #(
    parameter int unsigned OFS_W  = 8,
    parameter int unsigned N_GEN  = 8,
    parameter int unsigned N_ARCH = 4
) (
    input  logic [15:0]      key,
    output logic [OFS_W-1:0] len
);
    logic [13:0] idx;
    logic        arch;
    logic        unused_wr_flag;

    assign idx            = key[13:0];
    assign arch           = key[15];
    assign unused_wr_flag = key[14];

    always_comb begin
        len = '0;
        if (!arch) begin
            if (idx < 14'd2)
                len = OFS_W'(4);
            else if (32'(idx) < N_GEN)
                len = OFS_W'(32'(idx) * 3);
        end else begin
            if (32'(idx) < N_ARCH)
                len = OFS_W'(32'(idx) * 2 + 5);
        end
    end
endmodule

// File: rtl/cfg_item_byte.sv
module cfg_item_byte #(
    parameter int unsigned OFS_W     = 8,
    parameter logic [31:0] SIG       = 32'h4B43_4647,
    parameter logic        FEAT_BULK = 1'b1
) (
    input  logic [15:0]    key,
    input  logic [OFS_W:0] pos,
    output logic [7:0]     val
);
    localparam logic [31:0] FEAT_WORD = {30'd0, FEAT_BULK, 1'b1};

    logic [13:0] idx;
    logic        unused_wr_flag;
    logic [7:0]  sig_b;
    logic [7:0]  feat_b;

    assign idx            = key[13:0];
    assign unused_wr_flag = key[14];

    always_comb begin
        case (pos[1:0])
            2'd0:    sig_b = SIG[31:24];
            2'd1:    sig_b = SIG[23:16];
            2'd2:    sig_b = SIG[15:8];
            default: sig_b = SIG[7:0];
        endcase
        case (pos[1:0])
            2'd0:    feat_b = FEAT_WORD[7:0];
            2'd1:    feat_b = FEAT_WORD[15:8];
            2'd2:    feat_b = FEAT_WORD[23:16];
            default: feat_b = FEAT_WORD[31:24];
        endcase
    end

    always_comb begin
        if (key[15])
            val = 8'(32'h80 + 32'(idx) * 16 + 32'(pos));
        else if (idx == 14'd0)
            val = sig_b;
        else if (idx == 14'd1)
            val = feat_b;
        else
            val = 8'(32'(idx) * 16 + 32'(pos));
    end
endmodule

// File: rtl/cfg_lane.sv
module cfg_lane #(
    parameter int unsigned OFS_W     = 8,
    parameter int unsigned LANE      = 0,
    parameter logic [31:0] SIG       = 32'h4B43_4647,
    parameter logic        FEAT_BULK = 1'b1
) (
    input  logic [15:0]      key,
    input  logic [OFS_W-1:0] off,
    input  logic [OFS_W-1:0] len,
    input  logic             lane_en,
    output logic [7:0]       lane_byte
);
    logic [OFS_W:0] pos;
    logic [7:0]     raw;

    assign pos = {1'b0, off} + (OFS_W+1)'(LANE);

    cfg_item_byte #(
        .OFS_W(OFS_W), .SIG(SIG), .FEAT_BULK(FEAT_BULK)
    ) u_byte (
        .key(key), .pos(pos), .val(raw)
    );

    assign lane_byte = (lane_en && (pos < {1'b0, len})) ? raw : 8'h00;
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port #(
    parameter int unsigned OFS_W     = 8,
    parameter int unsigned N_GEN     = 8,
    parameter int unsigned N_ARCH    = 4,
    parameter logic [31:0] SIG       = 32'h4B43_4647,
    parameter logic        FEAT_BULK = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_we,
    input  logic [15:0] sel_wdata,
    input  logic        dat_re,
    input  logic        dat_we,
    input  logic [1:0]  dat_size,
    input  logic [63:0] dat_wdata,
    output logic [63:0] dat_rdata,
    output logic        dat_rvalid
);
    import kcfg_pkg::*;

    localparam int unsigned DW = 8 * LANES;

    typedef struct packed {
        logic [15:0]      key;
        logic [OFS_W-1:0] off;
        logic [DW-1:0]    rdata;
        logic             rvalid;
    } state_t;

    state_t s_d, s_q;

    logic [OFS_W-1:0]       cur_len;
    logic [LANES-1:0]       lane_en;
    logic [LANES-1:0][7:0]  lane_b;
    logic [DW-1:0]          lane_vec;
    logic [OFS_W:0]         adv_sum;
    logic                   unused_wr;

    assign unused_wr = ^{dat_we, dat_wdata};

    cfg_item_map #(
        .OFS_W(OFS_W), .N_GEN(N_GEN), .N_ARCH(N_ARCH)
    ) u_map (
        .key(s_q.key), .len(cur_len)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_en[k] = (k < acc_bytes(acc_size_e'(dat_size)));

        cfg_lane #(
            .OFS_W(OFS_W), .LANE(k), .SIG(SIG), .FEAT_BULK(FEAT_BULK)
        ) u_lane (
            .key(s_q.key), .off(s_q.off), .len(cur_len),
            .lane_en(lane_en[k]), .lane_byte(lane_b[k])
        );

        assign lane_vec[8*k +: 8] = lane_b[k];
    end

    assign adv_sum = {1'b0, s_q.off} + (OFS_W+1)'(acc_bytes(acc_size_e'(dat_size)));

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        if (sel_we) begin
            s_d.key = sel_wdata;
            s_d.off = '0;
        end else if (dat_re) begin
            s_d.rdata  = lane_vec;
            s_d.rvalid = 1'b1;
            s_d.off    = (adv_sum > {1'b0, cur_len}) ? cur_len : adv_sum[OFS_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign dat_rdata  = s_q.rdata;
    assign dat_rvalid = s_q.rvalid;

    assert_rewind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |=> (s_q.off == '0) && !dat_rvalid);

    assert_rvalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_re && !sel_we) |=> dat_rvalid);

    assert_no_stray_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_re && !sel_we) |=> !dat_rvalid);

    assert_off_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.off <= cur_len);

    assert_zero_past_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_re && !sel_we && (s_q.off >= cur_len)) |=> (dat_rdata == '0));

    assert_write_noop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !dat_re && !sel_we) |=> $stable(s_q.off) && $stable(s_q.key));
endmodule

// File: tb/sim_keyed_cfg_port.sv
module sim_keyed_cfg_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_we = 1'b0;
    logic [15:0] sel_wdata = '0;
    logic        dat_re = 1'b0;
    logic        dat_we = 1'b0;
    logic [1:0]  dat_size = '0;
    logic [63:0] dat_wdata = '0;
    logic [63:0] dat_rdata;
    logic        dat_rvalid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    logic [15:0] m_key = 16'h0000;
    int          m_off = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .dat_re(dat_re), .dat_we(dat_we), .dat_size(dat_size),
        .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .dat_rvalid(dat_rvalid)
    );

    function automatic int exp_len(logic [15:0] k);
        int i = int'(k[13:0]);
        if (k[15]) return (i < 4) ? 2*i + 5 : 0;
        if (i < 2) return 4;
        if (i < 8) return 3*i;
        return 0;
    endfunction

    function automatic logic [7:0] exp_byte(logic [15:0] k, int p);
        int i = int'(k[13:0]);
        if (p >= exp_len(k)) return 8'h00;
        if (k[15]) return 8'((128 + 16*i + p) % 256);
        if (i == 0) begin
            case (p)
                0: return 8'h4B;
                1: return 8'h43;
                2: return 8'h46;
                default: return 8'h47;
            endcase
        end
        if (i == 1) return (p == 0) ? 8'h03 : 8'h00;
        return 8'((16*i + p) % 256);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_select(logic [15:0] k);
        @(negedge clk);
        sel_we = 1'b1; sel_wdata = k;
        @(negedge clk);
        sel_we = 1'b0;
        m_key = k; m_off = 0;
    endtask

    task automatic do_read(logic [1:0] sz, string tag);
        int n = 1 << sz;
        logic [63:0] e = '0;
        for (int k = 0; k < n; k++) e[8*k +: 8] = exp_byte(m_key, m_off + k);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        dat_re = 1'b1; dat_size = sz;
        m_off = (m_off + n > exp_len(m_key)) ? exp_len(m_key) : m_off + n;
        @(negedge clk);
        dat_re = 1'b0;
    endtask

    task automatic do_write(logic [63:0] v);
        @(negedge clk);
        dat_we = 1'b1; dat_wdata = v; dat_size = 2'd3;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    // monitor: compares each returned read against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && dat_rvalid) begin
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R3: unexpected rvalid, actual %h expected none", dat_rdata);
            end else begin
                check(tag_q.pop_front(), dat_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdata at reset", dat_rdata, 64'h0);
        check("R1 rvalid at reset", {63'h0, dat_rvalid}, 64'h0);
        rst_n = 1'b1;

        // R1/R7: key 0 is selected from reset; read the signature in one go
        do_read(2'd2, "R7 signature word");
        do_read(2'd2, "R5 past end of signature");

        // R8, R4: feature word read with 8 bytes, upper lanes past the end
        do_select(16'h0001);
        do_read(2'd3, "R8 feature word");

        // R6: bit 14 set reaches the same item, byte-wise reads, R5 at the end
        do_select(16'h4001);
        for (int b = 0; b < 5; b++) do_read(2'd0, "R6 bit14 ignored byte read");

        // R9, R10, R4, R5: generic item 5, length 15
        do_select(16'h0005);
        do_read(2'd1, "R4 two-byte read");
        do_write(64'hFFFF_FFFF_FFFF_FFFF);
        do_read(2'd2, "R10 read after data write");
        do_read(2'd3, "R9 generic item eight bytes");
        do_read(2'd3, "R5 partial past end");
        do_read(2'd0, "R5 saturated offset");

        // R6, R9: architecture space index 2, length 9
        do_select(16'h8002);
        do_read(2'd3, "R6 arch item first eight");
        do_read(2'd1, "R9 arch item tail");

        // R2: rewind mid-item by reselecting
        do_select(16'h0003);
        do_read(2'd2, "R9 generic item 3");
        do_select(16'h0003);
        do_read(2'd1, "R2 rewind after reselect");

        // R9: nonexistent keys read zero
        do_select(16'h0100);
        do_read(2'd3, "R9 missing generic key");
        do_select(16'h8010);
        do_read(2'd3, "R9 missing arch key");

        // R2: read in the same cycle as a selector write is dropped
        @(negedge clk);
        sel_we = 1'b1; sel_wdata = 16'h0002; dat_re = 1'b1; dat_size = 2'd3;
        @(negedge clk);
        sel_we = 1'b0; dat_re = 1'b0;
        m_key = 16'h0002; m_off = 0;
        check("R2 no rvalid for dropped read", {63'h0, dat_rvalid}, 64'h0);
        do_read(2'd3, "R2 new key from offset zero");

        repeat (3) @(negedge clk);
        check("R3 scoreboard drained", 64'(exp_q.size()), 64'h0);
        finish_run();
    end
endmodule